// File: doc/BRIEF.md
# Two-Line Serial Port Interrupt Router

This block collects the interrupt events of a buffered serial port and routes them onto two level-sensitive interrupt outputs, line 0 and line 1. The transfer engine sends it single-cycle pulses: five transmission-error conditions, receive overrun, receive-buffer-full, transmit-buffer-empty, and per-transfer-group completion and suspend pulses. Each event sets a sticky flag. A flag drives an interrupt line only when its enable is set. A per-source level bit chooses which of the two lines it drives.

A mode input selects between two source sets. In compatibility mode, the eight port sources are live and transfer-group events only record flags. In multi-buffer mode, the receive-full and transmit-empty sources stop driving the lines, and the completion and suspend flags of each transfer group drive them instead. Every source that maps to a line is ORed onto that line, so software reads the flags to find which source caused an interrupt.

Software reaches all enables, level selects and flags through a small write/read register port. Flags are cleared by writing 1 to them.

Top module: `spi_irq_router`

## Requirements
- R1: After reset, every enable, level bit and flag reads 0, and both interrupt lines are low.
- R2: A pulse on any port event input sets its flag at the next clock edge, even when its enable is 0. The port flag bits are: 0 bit error, 1 desync, 2 data length, 3 parity, 4 timeout, 5 overrun, 6 receive full, 7 transmit empty.
- R3: Flags are sticky. Writing 1 to a flag bit clears it, and writing 0 leaves it alone. When an event and a clear hit the same flag in the same cycle, the flag stays set.
- R4: An interrupt line is a register. It reflects the flag, enable, level and mode state of the previous cycle, so it changes one cycle after the flag or enable changes.
- R5: A level bit of 0 routes its source to line 0, and a level bit of 1 routes it to line 1.
- R6: A line is high while at least one routed source is both flagged and enabled. Clearing one of several such sources leaves the line high.
- R7: In multi-buffer mode, port bits 6 and 7 never drive a line, whatever their enable is.
- R8: In multi-buffer mode, a flagged and enabled transfer-group completion drives the line chosen by that group's level bit.
- R9: In multi-buffer mode, a flagged and enabled transfer-group suspend drives the line chosen by that group's level bit. This is the same bit that routes its completion.
- R10: In compatibility mode, transfer-group flags still set but never drive a line.
- R11: Register map:
  - address 0: port enables [7:0]
  - address 1: port levels [7:0]
  - address 2: port flags [7:0], write 1 to clear
  - address 3: group completion enables [7:0] and suspend enables [15:8]
  - address 4: group levels [7:0]
  - address 5: group completion flags [7:0] and suspend flags [15:8], write 1 to clear
  - addresses 6 and 7 read 0.

  Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| multi_buf_mode | input | 1 | 1 selects multi-buffer source set |
| ev_err | input | 5 | Error condition pulses (bit, desync, length, parity, timeout) |
| ev_overrun | input | 1 | Receive overrun pulse |
| ev_rx_full | input | 1 | Receive buffer full pulse |
| ev_tx_empty | input | 1 | Transmit buffer empty pulse |
| ev_tg_done | input | N_TG | Transfer-group completion pulses |
| ev_tg_susp | input | N_TG | Transfer-group suspend pulses |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 2*N_TG | Register write data |
| bus_rdata | output | 2*N_TG | Register read data |
| irq_line0 | output | 1 | Interrupt line 0 |
| irq_line1 | output | 1 | Interrupt line 1 |
| port_flags | output | 8 | Port flag status |
| tg_flags | output | 2*N_TG | Group flags, suspend high half, completion low half |

## Verification
Inputs applied before edge k update the flags and registers at edge k, so flags and read data are compared just after that edge. Lines are due one edge later, at k+1, because they are computed from the state present before edge k+1. The bench follows the same rule: it works out the expected line from its model's state before each edge, and it advances the model only after that edge. Directed tests check both cycles explicitly: the flag is already set while the line is still low, and the line rises on the next cycle.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int PORT_SRC = 8;
  localparam int ERR_N    = 5;
  localparam int ADDR_W   = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_PORT_EN  = 3'd0,
    A_PORT_LVL = 3'd1,
    A_PORT_FLG = 3'd2,
    A_TG_EN    = 3'd3,
    A_TG_LVL   = 3'd4,
    A_TG_FLG   = 3'd5
  } reg_addr_e;

  // Port sources that may drive a line in the given mode.
  function automatic logic [PORT_SRC-1:0] port_live_mask(input logic mb);
    return mb ? 8'h3F : 8'hFF;
  endfunction

  // Next value of a sticky write-one-to-clear flag bank slice.
  function automatic logic [PORT_SRC-1:0] sticky8(input logic [PORT_SRC-1:0] cur,
                                                   input logic [PORT_SRC-1:0] set,
                                                   input logic [PORT_SRC-1:0] clr);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flags_o
);
  logic [W-1:0] flags_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~clr_i) | set_i;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import spi_irq_pkg::*;
#(
  parameter int N_TG  = 8,
  parameter int REG_W = 2 * N_TG
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [REG_W-1:0]    wdata_i,
  output logic [PORT_SRC-1:0] port_en_o,
  output logic [PORT_SRC-1:0] port_lvl_o,
  output logic [N_TG-1:0]     tg_done_en_o,
  output logic [N_TG-1:0]     tg_susp_en_o,
  output logic [N_TG-1:0]     tg_lvl_o
);
  logic [PORT_SRC-1:0] pen_q, plvl_q;
  logic [N_TG-1:0]     tden_q, tsen_q, tlvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pen_q  <= '0;
      plvl_q <= '0;
      tden_q <= '0;
      tsen_q <= '0;
      tlvl_q <= '0;
    end else if (we_i) begin
      case (addr_i)
        A_PORT_EN:  pen_q  <= wdata_i[PORT_SRC-1:0];
        A_PORT_LVL: plvl_q <= wdata_i[PORT_SRC-1:0];
        A_TG_EN: begin
          tden_q <= wdata_i[N_TG-1:0];
          tsen_q <= wdata_i[2*N_TG-1:N_TG];
        end
        A_TG_LVL:   tlvl_q <= wdata_i[N_TG-1:0];
        default: ;
      endcase
    end
  end

  assign port_en_o    = pen_q;
  assign port_lvl_o   = plvl_q;
  assign tg_done_en_o = tden_q;
  assign tg_susp_en_o = tsen_q;
  assign tg_lvl_o     = tlvl_q;
endmodule

// File: rtl/irq_line_merge.sv
module irq_line_merge #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pend_i,
  input  logic [W-1:0] en_i,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] live_i,
  output logic [1:0]   req_o,
  output logic [1:0]   line_o
);
  logic [W-1:0] active;
  assign active = pend_i & en_i & live_i;

  for (genvar g = 0; g < 2; g++) begin : g_line
    logic sel_req;
    assign sel_req  = |(active & ((g == 1) ? lvl_i : ~lvl_i));
    assign req_o[g] = sel_req;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_o[g] <= 1'b0;
      else        line_o[g] <= sel_req;
    end
  end
endmodule

// File: rtl/spi_irq_router.sv
module spi_irq_router
  import spi_irq_pkg::*;
#(
  parameter int N_TG = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                multi_buf_mode,
  input  logic [ERR_N-1:0]    ev_err,
  input  logic                ev_overrun,
  input  logic                ev_rx_full,
  input  logic                ev_tx_empty,
  input  logic [N_TG-1:0]     ev_tg_done,
  input  logic [N_TG-1:0]     ev_tg_susp,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [2*N_TG-1:0]   bus_wdata,
  output logic [2*N_TG-1:0]   bus_rdata,
  output logic                irq_line0,
  output logic                irq_line1,
  output logic [PORT_SRC-1:0] port_flags,
  output logic [2*N_TG-1:0]   tg_flags
);
  localparam int REG_W = 2 * N_TG;
  localparam int ALL_W = PORT_SRC + REG_W;

  // Named internal events.
  logic [PORT_SRC-1:0] ev_port;
  logic [REG_W-1:0]    ev_tg;
  logic [PORT_SRC-1:0] clr_port;
  logic [REG_W-1:0]    clr_tg;
  logic [PORT_SRC-1:0] port_en, port_lvl;
  logic [N_TG-1:0]     tg_done_en, tg_susp_en, tg_lvl;
  logic [REG_W-1:0]    tg_en;
  logic [1:0]          line_req;
  logic [1:0]          line_q;

  assign ev_port = {ev_tx_empty, ev_rx_full, ev_overrun, ev_err};
  assign ev_tg   = {ev_tg_susp, ev_tg_done};
  assign tg_en   = {tg_susp_en, tg_done_en};

  assign clr_port = (bus_we && bus_addr == A_PORT_FLG) ? bus_wdata[PORT_SRC-1:0] : '0;
  assign clr_tg   = (bus_we && bus_addr == A_TG_FLG)   ? bus_wdata : '0;

  irq_flag_bank #(.W(PORT_SRC)) u_port_flags (
    .clk(clk), .rst_n(rst_n), .set_i(ev_port), .clr_i(clr_port), .flags_o(port_flags)
  );

  irq_flag_bank #(.W(REG_W)) u_tg_flags (
    .clk(clk), .rst_n(rst_n), .set_i(ev_tg), .clr_i(clr_tg), .flags_o(tg_flags)
  );

  irq_cfg_regs #(.N_TG(N_TG), .REG_W(REG_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we_i(bus_we), .addr_i(bus_addr), .wdata_i(bus_wdata),
    .port_en_o(port_en), .port_lvl_o(port_lvl), .tg_done_en_o(tg_done_en),
    .tg_susp_en_o(tg_susp_en), .tg_lvl_o(tg_lvl)
  );

  irq_line_merge #(.W(ALL_W)) u_merge (
    .clk(clk), .rst_n(rst_n),
    .pend_i({tg_flags, port_flags}),
    .en_i({tg_en, port_en}),
    .lvl_i({tg_lvl, tg_lvl, port_lvl}),
    .live_i({{REG_W{multi_buf_mode}}, port_live_mask(multi_buf_mode)}),
    .req_o(line_req),
    .line_o(line_q)
  );

  assign irq_line0 = line_q[0];
  assign irq_line1 = line_q[1];

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_PORT_EN:  bus_rdata[PORT_SRC-1:0] = port_en;
      A_PORT_LVL: bus_rdata[PORT_SRC-1:0] = port_lvl;
      A_PORT_FLG: bus_rdata[PORT_SRC-1:0] = port_flags;
      A_TG_EN:    bus_rdata = tg_en;
      A_TG_LVL:   bus_rdata[N_TG-1:0] = tg_lvl;
      A_TG_FLG:   bus_rdata = tg_flags;
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_irq_router_chk.sv
module spi_irq_router_chk #(
  parameter int N_TG = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              multi_buf_mode,
  input logic [7:0]        ev_port,
  input logic              bus_we,
  input logic [2:0]        bus_addr,
  input logic [2*N_TG-1:0] bus_wdata,
  input logic [7:0]        port_flags,
  input logic [7:0]        port_en,
  input logic [2*N_TG-1:0] tg_flags,
  input logic [2*N_TG-1:0] tg_en,
  input logic [1:0]        line_req,
  input logic              irq_line0,
  input logic              irq_line1
);
  logic [7:0] clr_now;
  assign clr_now = (bus_we && bus_addr == 3'd2) ? bus_wdata[7:0] : 8'h00;

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!irq_line0 && !irq_line1 && port_flags == 8'h00 && tg_flags == '0)); // R1

  AST_EVENT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_port) |=> ((port_flags & $past(ev_port)) == $past(ev_port))); // R2

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_now & ~ev_port)) |=> ((port_flags & $past(clr_now & ~ev_port)) == 8'h00)); // R3

  AST_LINE_REGISTERED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_line0 == $past(line_req[0]) && irq_line1 == $past(line_req[1]))); // R4

  AST_MB_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (multi_buf_mode && !(|(port_flags[5:0] & port_en[5:0])) && !(|(tg_flags & tg_en)))
    |=> (!irq_line0 && !irq_line1)); // R7

  AST_COMPAT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!multi_buf_mode && !(|(port_flags & port_en))) |=> (!irq_line0 && !irq_line1)); // R10
endmodule

bind spi_irq_router spi_irq_router_chk #(.N_TG(N_TG)) u_chk (
  .clk(clk), .rst_n(rst_n), .multi_buf_mode(multi_buf_mode), .ev_port(ev_port),
  .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .port_flags(port_flags), .port_en(port_en), .tg_flags(tg_flags), .tg_en(tg_en),
  .line_req(line_req), .irq_line0(irq_line0), .irq_line1(irq_line1)
);

// File: tb/sim_spi_irq_router.sv
module sim_spi_irq_router;
  localparam int NT = 8;
  localparam int RW = 2 * NT;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode = 1'b0;
  logic [7:0] evp = '0;
  logic [NT-1:0] evd = '0, evs = '0;
  logic we = 1'b0;
  logic [2:0] addr = '0;
  logic [RW-1:0] wdata = '0;
  logic [RW-1:0] rdata;
  logic l0, l1;
  logic [7:0] pflg;
  logic [RW-1:0] tflg;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // Bench model state.
  logic [7:0] m_pen = '0, m_plvl = '0, m_pf = '0;
  logic [NT-1:0] m_tden = '0, m_tsen = '0, m_tlvl = '0, m_tdf = '0, m_tsf = '0;
  logic m_l0 = 1'b0, m_l1 = 1'b0;

  always #4 clk = ~clk;

  spi_irq_router #(.N_TG(NT)) u0 (
    .clk(clk), .rst_n(rst_n), .multi_buf_mode(mode),
    .ev_err(evp[4:0]), .ev_overrun(evp[5]), .ev_rx_full(evp[6]), .ev_tx_empty(evp[7]),
    .ev_tg_done(evd), .ev_tg_susp(evs),
    .bus_we(we), .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
    .irq_line0(l0), .irq_line1(l1), .port_flags(pflg), .tg_flags(tflg)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Expected line pair, walking each source in turn.
  function automatic logic [1:0] want_lines(input logic mb);
    logic [1:0] r = 2'b00;
    for (int i = 0; i < 8; i++) begin
      if (m_pf[i] && m_pen[i] && !(mb && i >= 6)) r[m_plvl[i]] = 1'b1;
    end
    if (mb) begin
      for (int g = 0; g < NT; g++) begin
        if ((m_tdf[g] && m_tden[g]) || (m_tsf[g] && m_tsen[g])) r[m_tlvl[g]] = 1'b1;
      end
    end
    return r;
  endfunction

  function automatic logic [RW-1:0] want_read(input logic [2:0] a);
    case (a)
      3'd0: return {8'h00, m_pen};
      3'd1: return {8'h00, m_plvl};
      3'd2: return {8'h00, m_pf};
      3'd3: return {m_tsen, m_tden};
      3'd4: return {8'h00, m_tlvl};
      3'd5: return {m_tsf, m_tdf};
      default: return '0;
    endcase
  endfunction

  // One clock: inputs are already applied; model advances after the edge.
  task automatic step();
    logic [1:0] nl;
    logic [7:0] pclr;
    logic [RW-1:0] tclr;
    nl   = want_lines(mode);
    pclr = (we && addr == 3'd2) ? wdata[7:0] : 8'h00;
    tclr = (we && addr == 3'd5) ? wdata : '0;
    @(posedge clk);
    #2;
    m_pf  = (m_pf & ~pclr) | evp;
    m_tdf = (m_tdf & ~tclr[NT-1:0]) | evd;
    m_tsf = (m_tsf & ~tclr[RW-1:NT]) | evs;
    if (we) begin
      case (addr)
        3'd0: m_pen  = wdata[7:0];
        3'd1: m_plvl = wdata[7:0];
        3'd3: begin m_tden = wdata[NT-1:0]; m_tsen = wdata[RW-1:NT]; end
        3'd4: m_tlvl = wdata[NT-1:0];
        default: ;
      endcase
    end
    m_l0 = nl[0];
    m_l1 = nl[1];
    chk("R4 line0", l0, m_l0);
    chk("R4 line1", l1, m_l1);
    chk("R2 port flags", pflg, m_pf);
    chk("R3 group flags", tflg, {m_tsf, m_tdf});
    evp = '0; evd = '0; evs = '0; we = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [RW-1:0] d);
    we = 1'b1; addr = a; wdata = d;
    step();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R4 actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    repeat (3) @(posedge clk);
    #2;
    chk("R1 line0 in reset", l0, 0);
    chk("R1 line1 in reset", l1, 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 8; a++) begin
      addr = 3'(a); #1;
      chk("R1 reset readback", rdata, 0);
    end
    idle(2);

    // R2: flag sets with enable clear; no line.
    evp = 8'h08; step();
    chk("R2 parity flag without enable", pflg, 8'h08);
    step();
    chk("R2 disabled source leaves line0 low", l0, 0);

    // R3: write-one clear, and set beats clear.
    wr(3'd2, 16'h0008);
    chk("R3 flag cleared", pflg, 8'h00);
    evp = 8'h02; step();
    evp = 8'h02; we = 1'b1; addr = 3'd2; wdata = 16'h0002; step();
    chk("R3 event wins over clear", pflg[1], 1);
    wr(3'd2, 16'h00FD);
    chk("R3 zero bits untouched", pflg[1], 1);
    wr(3'd2, 16'h00FF);

    // R4/R5: enable bit0 on line 0, then move it to line 1.
    wr(3'd0, 16'h0001);
    evp = 8'h01; step();
    chk("R4 flag set, line0 not yet", l0, 0);
    step();
    chk("R4 line0 one cycle later", l0, 1);
    wr(3'd1, 16'h0001);
    chk("R4 line0 still old level at write edge", l0, 1);
    step();
    chk("R5 routed to line1", l1, 1);
    chk("R5 line0 released", l0, 0);

    // R6: two sources share line 1; clearing one keeps it up.
    wr(3'd0, 16'h0021);
    wr(3'd1, 16'h0021);
    evp = 8'h20; step();
    wr(3'd2, 16'h0001);
    step();
    chk("R6 shared line stays high", l1, 1);
    wr(3'd2, 16'h0020);
    step();
    chk("R6 line drops when last source clears", l1, 0);

    // R7: multi-buffer mode ignores receive full / transmit empty.
    mode = 1'b1;
    wr(3'd0, 16'h00C0);
    wr(3'd1, 16'h0000);
    evp = 8'hC0; step();
    idle(2);
    chk("R7 rx_full/tx_empty muted", {l1, l0}, 2'b00);
    mode = 1'b0;
    idle(2);
    chk("R7 same sources live in compat", l0, 1);
    wr(3'd2, 16'h00FF);
    wr(3'd0, 16'h0000);

    // R8/R9: transfer groups in multi-buffer mode.
    mode = 1'b1;
    wr(3'd3, 16'h2004);
    wr(3'd4, 16'h0020);
    evd = 8'h04; step();
    idle(1);
    chk("R8 group2 completion on line0", {l1, l0}, 2'b01);
    evs = 8'h20; step();
    idle(1);
    chk("R9 group5 suspend on line1", l1, 1);
    wr(3'd5, 16'h2004);
    idle(1);
    chk("R9 group flags cleared, lines low", {l1, l0}, 2'b00);

    // R10: compat mode ignores group flags.
    mode = 1'b0;
    evd = 8'h04; evs = 8'h20; step();
    idle(2);
    chk("R10 group flags set", tflg, 16'h2004);
    chk("R10 group flags do not drive lines", {l1, l0}, 2'b00);
    wr(3'd5, 16'hFFFF);

    // R11: readback of every address.
    wr(3'd0, 16'h005A);
    wr(3'd1, 16'h00C3);
    wr(3'd3, 16'hA55A);
    wr(3'd4, 16'h0096);
    for (int a = 0; a < 8; a++) begin
      addr = 3'(a); #1;
      chk("R11 readback", rdata, want_read(3'(a)));
    end

    // Random traffic against the model.
    for (int c = 0; c < 4000; c++) begin
      if (($urandom % 97) == 0) mode = ~mode;
      evp = 8'($urandom) & 8'($urandom) & 8'($urandom);
      evd = 8'($urandom) & 8'($urandom) & 8'($urandom);
      evs = 8'($urandom) & 8'($urandom) & 8'($urandom);
      if (($urandom % 4) == 0) begin
        we = 1'b1; addr = 3'($urandom % 8); wdata = 16'($urandom);
      end
      step();
      if ((c % 16) == 0) begin
        addr = 3'($urandom % 8); #1;
        chk("R11 random readback", rdata, want_read(addr));
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule